// File: doc/BRIEF.md
# Accumulator Register-Operation Unit

This block keeps the 16-bit accumulator and the one-bit extend flag of a small accumulator machine. It carries out the register-operation instruction group. In that group every low instruction bit switches on one independent action: clearing, complementing, rotating through the extend flag, incrementing, testing for a skip, or halting. A single instruction word may set any mix of these bits. The unit applies the selected actions in a fixed order within one clock. Skip and halt are reported to the surrounding sequencer, which owns the program counter.

The unit also accepts clear, load and increment commands from the memory-operation path of the machine. A load takes its value from one of several sources: the data register, the input character, the AND of the accumulator with the data register, or their sum. Those commands and the register-operation strobe share the accumulator, so the block settles by fixed priority which of them wins in a given cycle.

The control core is a two-state machine. In `ST_RUN` all updates are accepted. The transition `RUN_TO_HALT` is taken on the clock edge that executes an instruction with the halt bit set. `ST_HALT` holds through the transition `HALT_HOLD` until reset. Reset always returns the machine to `ST_RUN`.

Top module: `acc_regop_unit`

## Requirements
- R1: While rst_n is low and on the first cycle after it, ac_o is 0, e_o is 0, skip_o is 0 and halt_o is 0.
- R2: A register operation runs only on an edge where exec_i is 1 and instr_i[15:12] equals 4'b0111. With any other value of those bits the strobe changes neither ac_o nor e_o, and raises no skip.
- R3: Instruction bit 11 clears the accumulator. Bit 10 clears E.
- R4: Instruction bit 9 inverts every accumulator bit. Bit 8 inverts E.
- R5: Bit 7 rotates right through E: AC becomes {E, AC[15:1]} and E becomes AC[0]. Bit 6 rotates left through E: AC becomes {AC[14:0], E} and E becomes AC[15].
- R6: Instruction bit 5 adds one to AC modulo 2^16 and leaves E unchanged.
- R7: When several bits are set in one word, the actions apply in this order: the clears (bit 11, bit 10), then the complements (bit 9, bit 8), then the right rotate, then the left rotate, then the increment.
- R8: Bit 4 skips if AC[15] is 0. Bit 3 skips if AC[15] is 1. Bit 2 skips if AC is zero. Bit 1 skips if E is 0. The tests use the AC and E values from before the instruction, and their results are ORed. skip_o is 1 for exactly the one cycle that follows the executing edge.
- R9: Bit 0 moves the machine to the halted state. The other actions in the same word still take effect. halt_o is then 1 until reset, and every register-operation strobe and every external command is ignored.
- R10: Among the external commands, ac_clr_i beats ac_load_i, which beats ac_inc_i. ac_inc_i adds one to AC modulo 2^16 and leaves E unchanged.
- R11: The ac_load_i source is chosen by ac_src_i. Code 0 loads dr_i. Code 1 replaces AC[7:0] with char_i and keeps AC[15:8]. Code 2 loads AC AND dr_i. Code 3 loads AC + dr_i modulo 2^16 and puts the carry out of bit 15 into E. Only code 3 changes E.
- R12: On an edge where a valid register operation runs, all external commands are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_i | input | 1 | Register-operation execute strobe |
| instr_i | input | 16 | Instruction word |
| dr_i | input | 16 | Data register value |
| char_i | input | 8 | Input character |
| ac_clr_i | input | 1 | External clear command |
| ac_load_i | input | 1 | External load command |
| ac_inc_i | input | 1 | External increment command |
| ac_src_i | input | 2 | Load source code |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Extend flag |
| skip_o | output | 1 | Skip request pulse |
| halt_o | output | 1 | Halted |

## Verification
The register-operation strobe and an external accumulator command can both arrive on the same edge. The bench raises exec_i with a valid word together with ac_load_i, ac_clr_i or ac_inc_i, both in directed cases and in a long run of random stimulus. A cycle-by-cycle behavioural model gives priority to the instruction, and every output is compared on each clock. A second coincidence is a halt and a skip in one word. There the bench expects a one-cycle skip pulse on the same edge that halt_o rises.

// File: rtl/acc_regop_pkg.sv
package acc_regop_pkg;

    localparam int INSTR_W = 16;
    localparam int NUM_OPS = 12;
    localparam logic [3:0] REGOP_CLASS = 4'b0111;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        SRC_DR   = 2'd0,
        SRC_CHAR = 2'd1,
        SRC_AND  = 2'd2,
        SRC_ADD  = 2'd3
    } ld_src_e;

    // First member is the most significant bit: cla sits on bit 11, hlt on bit 0.
    typedef struct packed {
        logic cla;
        logic cle;
        logic cma;
        logic cme;
        logic cir;
        logic cil;
        logic inc;
        logic spa;
        logic sna;
        logic sza;
        logic sze;
        logic hlt;
    } regop_t;

endpackage

// File: rtl/regop_decode.sv
module regop_decode
    import acc_regop_pkg::*;
(
    input  logic               exec_i,
    input  logic               enable_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               valid_o,
    output regop_t             ops_o
);

    logic class_hit;

    always_comb begin
        class_hit = (instr_i[INSTR_W-1:INSTR_W-4] == REGOP_CLASS);
        valid_o   = exec_i && enable_i && class_hit;
        ops_o     = valid_o ? regop_t'(instr_i[NUM_OPS-1:0]) : '0;
    end

endmodule

// File: rtl/regop_alu.sv
module regop_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] ac_i,
    input  logic              e_i,
    input  logic              cla_i,
    input  logic              cle_i,
    input  logic              cma_i,
    input  logic              cme_i,
    input  logic              cir_i,
    input  logic              cil_i,
    input  logic              inc_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              e_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] a;
    logic              e;
    logic              spill;

    // Actions are applied in a fixed order: clears, complements,
    // right rotate, left rotate, increment.
    always_comb begin
        a = ac_i;
        e = e_i;
        if (cla_i) a = '0;
        if (cle_i) e = 1'b0;
        if (cma_i) a = ~a;
        if (cme_i) e = ~e;
        if (cir_i) begin
            spill = a[0];
            a     = {e, a[MSB:1]};
            e     = spill;
        end
        if (cil_i) begin
            spill = a[MSB];
            a     = {a[MSB-1:0], e};
            e     = spill;
        end
        if (inc_i) a = a + 1'b1;
        spill = 1'b0;
        ac_o  = a;
        e_o   = e;
    end

endmodule

// File: rtl/skip_eval.sv
module skip_eval #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] ac_i,
    input  logic              e_i,
    input  logic              spa_i,
    input  logic              sna_i,
    input  logic              sza_i,
    input  logic              sze_i,
    output logic              skip_o
);

    localparam int MSB = DATA_W - 1;

    logic sign;
    logic zero;

    always_comb begin
        sign   = ac_i[MSB];
        zero   = (ac_i == '0);
        skip_o = (spa_i && !sign) || (sna_i && sign) ||
                 (sza_i && zero)  || (sze_i && !e_i);
    end

endmodule

// File: rtl/memop_path.sv
module memop_path
    import acc_regop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic [DATA_W-1:0] ac_i,
    input  logic              e_i,
    input  logic [DATA_W-1:0] dr_i,
    input  logic [CHAR_W-1:0] char_i,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic              inc_i,
    input  logic [1:0]        src_i,
    output logic              touch_o,
    output logic [DATA_W-1:0] ac_o,
    output logic              e_o
);

    logic [DATA_W:0] sum;
    ld_src_e         src;

    always_comb begin
        src     = ld_src_e'(src_i);
        sum     = {1'b0, ac_i} + {1'b0, dr_i};
        touch_o = clr_i || load_i || inc_i;
        ac_o    = ac_i;
        e_o     = e_i;
        if (clr_i) begin
            ac_o = '0;
        end else if (load_i) begin
            unique case (src)
                SRC_DR:   ac_o = dr_i;
                SRC_CHAR: ac_o = {ac_i[DATA_W-1:CHAR_W], char_i};
                SRC_AND:  ac_o = ac_i & dr_i;
                SRC_ADD: begin
                    ac_o = sum[DATA_W-1:0];
                    e_o  = sum[DATA_W];
                end
                default:  ac_o = ac_i;
            endcase
        end else if (inc_i) begin
            ac_o = ac_i + 1'b1;
        end
    end

endmodule

// File: rtl/acc_regop_unit.sv
module acc_regop_unit
    import acc_regop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  dr_i,
    input  logic [CHAR_W-1:0]  char_i,
    input  logic               ac_clr_i,
    input  logic               ac_load_i,
    input  logic               ac_inc_i,
    input  logic [1:0]         ac_src_i,
    output logic [DATA_W-1:0]  ac_o,
    output logic               e_o,
    output logic               skip_o,
    output logic               halt_o
);

    run_state_e        state_q, state_d;
    logic              running;
    logic              op_valid;
    regop_t            ops;
    logic [DATA_W-1:0] ac_q, alu_ac, mem_ac;
    logic              e_q, alu_e, mem_e;
    logic              skip_q, skip_hit, mem_touch;

    regop_decode u_decode (
        .exec_i   (exec_i),
        .enable_i (running),
        .instr_i  (instr_i),
        .valid_o  (op_valid),
        .ops_o    (ops)
    );

    regop_alu #(.DATA_W(DATA_W)) u_alu (
        .ac_i  (ac_q),
        .e_i   (e_q),
        .cla_i (ops.cla),
        .cle_i (ops.cle),
        .cma_i (ops.cma),
        .cme_i (ops.cme),
        .cir_i (ops.cir),
        .cil_i (ops.cil),
        .inc_i (ops.inc),
        .ac_o  (alu_ac),
        .e_o   (alu_e)
    );

    skip_eval #(.DATA_W(DATA_W)) u_skip (
        .ac_i   (ac_q),
        .e_i    (e_q),
        .spa_i  (ops.spa),
        .sna_i  (ops.sna),
        .sza_i  (ops.sza),
        .sze_i  (ops.sze),
        .skip_o (skip_hit)
    );

    memop_path #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_mem (
        .ac_i    (ac_q),
        .e_i     (e_q),
        .dr_i    (dr_i),
        .char_i  (char_i),
        .clr_i   (ac_clr_i),
        .load_i  (ac_load_i),
        .inc_i   (ac_inc_i),
        .src_i   (ac_src_i),
        .touch_o (mem_touch),
        .ac_o    (mem_ac),
        .e_o     (mem_e)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state: RUN_TO_HALT on an executed halt bit, HALT_HOLD until reset
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (op_valid && ops.hlt) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_RUN;
        endcase
    end

    // State outputs
    always_comb begin
        running = 1'b0;
        halt_o  = 1'b0;
        unique case (state_q)
            ST_RUN:  running = 1'b1;
            ST_HALT: halt_o  = 1'b1;
            default: running = 1'b0;
        endcase
    end

    // Accumulator, extend flag and skip pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q   <= '0;
            e_q    <= 1'b0;
            skip_q <= 1'b0;
        end else if (op_valid) begin
            ac_q   <= alu_ac;
            e_q    <= alu_e;
            skip_q <= skip_hit;
        end else begin
            skip_q <= 1'b0;
            if (running && mem_touch) begin
                ac_q <= mem_ac;
                e_q  <= mem_e;
            end
        end
    end

    assign ac_o   = ac_q;
    assign e_o    = e_q;
    assign skip_o = skip_q;

endmodule

// File: rtl/acc_regop_chk.sv
module acc_regop_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_i,
    input logic [15:0]       instr_i,
    input logic              ac_clr_i,
    input logic              ac_load_i,
    input logic              ac_inc_i,
    input logic [DATA_W-1:0] ac_o,
    input logic              e_o,
    input logic              skip_o,
    input logic              halt_o
);

    logic is_reg;
    logic any_ext;
    assign is_reg  = exec_i && (instr_i[15:12] == 4'b0111);
    assign any_ext = ac_clr_i || ac_load_i || ac_inc_i;

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> ($stable(ac_o) && $stable(e_o) && !skip_o));

    assert_skip_needs_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> ($past(exec_i) && ($past(instr_i[15:12]) == 4'b0111)));

    assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_o && exec_i && !is_reg && !any_ext) |=>
            ($stable(ac_o) && $stable(e_o) && !skip_o));

    assert_cla_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_o && exec_i && instr_i == 16'h7800) |=> ((ac_o == '0) && $stable(e_o)));

    assert_inc_keeps_e_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_o && exec_i && instr_i == 16'h7020) |=>
            ((ac_o == DATA_W'($past(ac_o) + 1'b1)) && $stable(e_o)));

    assert_ext_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_o && ac_clr_i && !is_reg) |=> (ac_o == '0));

    assert_reg_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_o && exec_i && instr_i == 16'h7000 && any_ext) |=>
            ($stable(ac_o) && $stable(e_o)));

endmodule

bind acc_regop_unit acc_regop_chk #(.DATA_W(DATA_W)) u_acc_regop_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec_i),
    .instr_i   (instr_i),
    .ac_clr_i  (ac_clr_i),
    .ac_load_i (ac_load_i),
    .ac_inc_i  (ac_inc_i),
    .ac_o      (ac_o),
    .e_o       (e_o),
    .skip_o    (skip_o),
    .halt_o    (halt_o)
);

// File: tb/test_acc_regop_unit.sv
`timescale 1ns/1ps
module test_acc_regop_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [15:0] dr_i = '0;
    logic [7:0]  char_i = '0;
    logic        ac_clr_i = 1'b0, ac_load_i = 1'b0, ac_inc_i = 1'b0;
    logic [1:0]  ac_src_i = '0;
    logic [15:0] ac_o;
    logic        e_o, skip_o, halt_o;

    int checks = 0;
    int fails  = 0;
    int m_ac = 0, m_e = 0, m_skip = 0, m_halt = 0;

    always #2 clk = ~clk;

    acc_regop_unit i_acc_regop_unit (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i),
        .dr_i(dr_i), .char_i(char_i), .ac_clr_i(ac_clr_i), .ac_load_i(ac_load_i),
        .ac_inc_i(ac_inc_i), .ac_src_i(ac_src_i), .ac_o(ac_o), .e_o(e_o),
        .skip_o(skip_o), .halt_o(halt_o)
    );

    task automatic model_step();
        int w, a, e, s, t;
        if (!rst_n) begin
            m_ac = 0; m_e = 0; m_skip = 0; m_halt = 0;
            return;
        end
        if (m_halt != 0) begin
            m_skip = 0;
            return;
        end
        a = m_ac; e = m_e; s = 0;
        if (exec_i && instr_i[15:12] == 4'd7) begin
            w = int'(instr_i[11:0]);
            if (((w >> 4) & 1) == 1 && a < 32768)  s = 1;
            if (((w >> 3) & 1) == 1 && a >= 32768) s = 1;
            if (((w >> 2) & 1) == 1 && a == 0)     s = 1;
            if (((w >> 1) & 1) == 1 && e == 0)     s = 1;
            if (((w >> 11) & 1) == 1) a = 0;
            if (((w >> 10) & 1) == 1) e = 0;
            if (((w >> 9) & 1) == 1)  a = 65535 - a;
            if (((w >> 8) & 1) == 1)  e = 1 - e;
            if (((w >> 7) & 1) == 1) begin t = a % 2; a = e * 32768 + a / 2; e = t; end
            if (((w >> 6) & 1) == 1) begin t = a / 32768; a = (a * 2) % 65536 + e; e = t; end
            if (((w >> 5) & 1) == 1)  a = (a + 1) % 65536;
            if ((w & 1) == 1) m_halt = 1;
        end else if (ac_clr_i) begin
            a = 0;
        end else if (ac_load_i) begin
            case (ac_src_i)
                2'd0: a = int'(dr_i);
                2'd1: a = (a / 256) * 256 + int'(char_i);
                2'd2: a = a & int'(dr_i);
                default: begin t = a + int'(dr_i); a = t % 65536; e = t / 65536; end
            endcase
        end else if (ac_inc_i) begin
            a = (a + 1) % 65536;
        end
        m_ac = a; m_e = e; m_skip = s;
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        #1;
        checks++;
        if (ac_o !== 16'(m_ac) || e_o !== 1'(m_e) || skip_o !== 1'(m_skip) || halt_o !== 1'(m_halt)) begin
            fails++;
            $display("FAIL %s: ac=%h e=%b skip=%b halt=%b expected ac=%h e=%0d skip=%0d halt=%0d",
                     tag, ac_o, e_o, skip_o, halt_o, 16'(m_ac), m_e, m_skip, m_halt);
        end
    endtask

    task automatic idle();
        exec_i = 0; ac_clr_i = 0; ac_load_i = 0; ac_inc_i = 0;
    endtask

    task automatic run_op(input logic [15:0] w, input string tag);
        idle(); exec_i = 1; instr_i = w; tick(tag);
        idle(); tick(tag);
    endtask

    task automatic load(input logic [1:0] src, input logic [15:0] d, input string tag);
        idle(); ac_load_i = 1; ac_src_i = src; dr_i = d; tick(tag);
        idle();
    endtask

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0;
        tick("R1"); tick("R1");
        rst_n = 1;
        tick("R1");
        // rotates (R5)
        load(2'd0, 16'h8001, "R11");
        run_op(16'h7080, "R5");
        run_op(16'h7040, "R5");
        run_op(16'h7040, "R5");
        // complements and clears (R4, R3)
        run_op(16'h7100, "R4");
        run_op(16'h7200, "R4");
        run_op(16'h7400, "R3");
        run_op(16'h7800, "R3");
        // ordering of combined bits (R7)
        run_op(16'h7A20, "R7");
        load(2'd0, 16'h1234, "R11");
        run_op(16'h7220, "R7");
        run_op(16'h7EC0, "R7");
        run_op(16'h73A0, "R7");
        // increment wraps, E kept (R6)
        load(2'd0, 16'hFFFF, "R11");
        run_op(16'h7020, "R6");
        // skips on pre-instruction values (R8)
        run_op(16'h7004, "R8");
        run_op(16'h7824, "R8");
        run_op(16'h7010, "R8");
        run_op(16'h7208, "R8");
        run_op(16'h7002, "R8");
        run_op(16'h7102, "R8");
        run_op(16'h7012, "R8");
        // foreign words ignored (R2)
        run_op(16'h3FFE, "R2");
        run_op(16'hF800, "R2");
        run_op(16'h6020, "R2");
        idle(); instr_i = 16'h7800; tick("R2");
        // load sources (R11)
        char_i = 8'h5A;
        load(2'd1, 16'h0000, "R11");
        load(2'd2, 16'h0F0F, "R11");
        load(2'd0, 16'hFFFF, "R11");
        load(2'd3, 16'h0001, "R11");
        load(2'd3, 16'h7000, "R11");
        tick("R11");
        // external priority (R10)
        idle(); ac_clr_i = 1; ac_load_i = 1; ac_inc_i = 1; ac_src_i = 2'd0; dr_i = 16'hBEEF; tick("R10");
        idle(); ac_load_i = 1; ac_inc_i = 1; tick("R10");
        idle(); ac_inc_i = 1; tick("R10");
        idle(); tick("R10");
        // register op beats external (R12)
        idle(); exec_i = 1; instr_i = 16'h7800; ac_load_i = 1; ac_src_i = 2'd0; dr_i = 16'h4321; tick("R12");
        idle(); exec_i = 1; instr_i = 16'h7000; ac_clr_i = 1; tick("R12");
        idle(); exec_i = 1; instr_i = 16'h7020; ac_inc_i = 1; ac_load_i = 1; ac_src_i = 2'd3; tick("R12");
        idle(); tick("R12");
        // random mixed stimulus, halt bit masked
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            exec_i    = r[0];
            instr_i   = r[1] ? {4'b0111, 12'($urandom) & 12'hFFE} : 16'($urandom) & 16'hFFFE;
            ac_clr_i  = (r[5:2] == 4'd0);
            ac_load_i = r[6];
            ac_inc_i  = r[7];
            ac_src_i  = r[9:8];
            dr_i      = 16'($urandom);
            char_i    = 8'($urandom);
            tick("R7");
        end
        // halt with skip, then frozen (R9)
        load(2'd0, 16'h0000, "R11");
        idle(); exec_i = 1; instr_i = 16'h7225; tick("R9");
        idle(); exec_i = 1; instr_i = 16'h7800; tick("R9");
        idle(); ac_clr_i = 1; ac_load_i = 1; tick("R9");
        idle(); ac_inc_i = 1; tick("R9");
        idle(); exec_i = 1; instr_i = 16'h7004; tick("R9");
        idle(); tick("R9");
        // reset leaves the halted state (R1)
        rst_n = 0; tick("R1");
        rst_n = 1; tick("R1");
        run_op(16'h7020, "R6");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule